// File: doc/BRIEF.md
# Barrel Shifter With Carry-Out

This block is a purely combinational word shifter for a processor datapath. It takes a W-bit operand, a 3-bit shift-kind code, an amount and an incoming carry flag. In the same cycle it returns the shifted word and the carry-out that a flag-setting instruction would latch.

Each shift kind has its own carry-out rule:

- Left and logical-right shifts report the last bit pushed off the end of the word.
- Arithmetic-right shifts clamp the bit position, so a long shift reports the sign bit.
- Rotates report the new top bit.
- The one-bit extended rotate passes through the carry flag.

The four amount-driven kinds have no defined carry when the amount is zero. For that case the block lowers `valid_o` and passes both the operand and the carry through unchanged. The caller decides what to do with them.

Choosing between an immediate amount and a register amount, reading operands and writing the flag register all happen outside this block.

Top module: `shift_carry_unit`

## Requirements
- R1: `kind_i` encodes 0 = shift left, 1 = logical shift right, 2 = arithmetic shift right, 3 = rotate right, 4 = extended rotate right. Codes 5 to 7 drive `valid_o` low, `result_o` = `operand_i` and `carry_o` = `carry_i`.
- R2: For shift left with 1 <= amount <= W, the result is the operand shifted left with zeros entering at the bottom, and the carry is operand bit W-amount.
- R3: For logical shift right with 1 <= amount <= W, the result is the operand shifted right with zeros entering at the top, and the carry is operand bit amount-1.
- R4: For arithmetic shift right with amount >= 1, the result is the operand shifted right with copies of bit W-1 entering at the top. The carry is operand bit min(W-1, amount-1), so any amount >= W gives an all-sign result and a carry equal to bit W-1.
- R5: For rotate right with amount >= 1, the result is the operand rotated right by amount modulo W, and the carry is bit W-1 of that result. An amount that is a nonzero multiple of W leaves the word unchanged.
- R6: For extended rotate right, the result is `{carry_i, operand_i[W-1:1]}` and the carry is `operand_i[0]`. `amount_i` has no effect, and `valid_o` is high for every amount.
- R7: For codes 0 to 3 with amount 0, `valid_o` is low, `result_o` = `operand_i` and `carry_o` = `carry_i`. In every other defined case `valid_o` is high.
- R8: Shift left and logical shift right by more than W give a zero result and a zero carry. A shift by exactly W gives a zero result, with carry `operand_i[0]` for shift left and `operand_i[W-1]` for logical shift right.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | W | Word to be shifted |
| kind_i | input | 3 | Shift kind code (see R1) |
| amount_i | input | AW | Shift or rotate amount, 0 to 2^AW-1 (default up to 255) |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | W | Shifted word |
| carry_o | output | 1 | Outgoing carry flag |
| valid_o | output | 1 | Low when the carry is undefined or the code is unused |

## Verification
An 8-bit instance is tried with every operand value under all eight kind codes, both carry values and amounts 0 to 10, 15, 16, 100 and 255. The small amounts tell apart the per-bit carry rules of each kind. Amounts 7, 8 and 9 separate the below-width case, the exactly-width case and the beyond-width case for left and logical shifts, and the sign clamp for arithmetic shifts. Amounts 16, 100 and 255 show whether rotation wraps modulo the width and whether extended rotation ignores the amount. A 32-bit instance gets directed cases at the default width, including a rotate by 33 that must match a rotate by 1.

// File: rtl/shift_carry_unit.sv
module shift_carry_unit #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic [W-1:0]  operand_i,
  input  logic [2:0]    kind_i,
  input  logic [AW-1:0] amount_i,
  input  logic          carry_i,
  output logic [W-1:0]  result_o,
  output logic          carry_o,
  output logic          valid_o
);

  localparam logic [2:0] K_LSL = 3'd0;
  localparam logic [2:0] K_LSR = 3'd1;
  localparam logic [2:0] K_ASR = 3'd2;
  localparam logic [2:0] K_ROR = 3'd3;
  localparam logic [2:0] K_RRX = 3'd4;

  logic          amt_zero;
  logic [W:0]    lsl_ext;
  logic [W:0]    lsr_ext;
  logic [W:0]    asr_ext;
  logic [AW-1:0] rot_amt;
  logic [W-1:0]  ror_res;

  assign amt_zero = (amount_i == '0);

  // one extra bit below (right shifts) or above (left shift) catches the last bit shifted out
  assign lsl_ext = {1'b0, operand_i} << amount_i;
  assign lsr_ext = {operand_i, 1'b0} >> amount_i;
  assign asr_ext = $signed({operand_i, 1'b0}) >>> amount_i;

  assign rot_amt = amount_i % AW'(W);
  assign ror_res = (operand_i >> rot_amt) | (operand_i << (AW'(W) - rot_amt));

  always_comb begin
    result_o = operand_i;
    carry_o  = carry_i;
    valid_o  = 1'b0;
    case (kind_i)
      K_LSL: if (!amt_zero) begin
        result_o = lsl_ext[W-1:0];
        carry_o  = lsl_ext[W];
        valid_o  = 1'b1;
      end
      K_LSR: if (!amt_zero) begin
        result_o = lsr_ext[W:1];
        carry_o  = lsr_ext[0];
        valid_o  = 1'b1;
      end
      K_ASR: if (!amt_zero) begin
        result_o = asr_ext[W:1];
        carry_o  = asr_ext[0];
        valid_o  = 1'b1;
      end
      K_ROR: if (!amt_zero) begin
        result_o = ror_res;
        carry_o  = ror_res[W-1];
        valid_o  = 1'b1;
      end
      K_RRX: begin
        result_o = {carry_i, operand_i[W-1:1]};
        carry_o  = operand_i[0];
        valid_o  = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown({operand_i, kind_i, amount_i, carry_i})) begin
      a_r7_idle_passthrough: assert (valid_o || (result_o == operand_i && carry_o == carry_i))
        else $error("R7: invalid case did not pass operand and carry through");
      a_r8_wide_zero: assert (!((kind_i == K_LSL || kind_i == K_LSR) && int'(amount_i) >= W) || result_o == '0)
        else $error("R8: shift by W or more left nonzero bits");
      a_r4_sign_kept: assert (!(kind_i == K_ASR && valid_o) || result_o[W-1] == operand_i[W-1])
        else $error("R4: arithmetic shift changed the sign bit");
      a_r5_bits_conserved: assert (kind_i != K_ROR || $countones(result_o) == $countones(operand_i))
        else $error("R5: rotate changed the number of set bits");
      a_r6_rrx_always_valid: assert (kind_i != K_RRX || (valid_o && carry_o == operand_i[0]))
        else $error("R6: extended rotate not valid or wrong carry");
      a_r1_unused_code: assert (kind_i <= K_RRX || !valid_o)
        else $error("R1: unused kind code reported valid");
    end
  end

endmodule

// File: tb/shift_carry_unit_tb_top.sv
module shift_carry_unit_tb_top;

  localparam int N = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0] op;
  logic [2:0]   kind;
  logic [7:0]   amt;
  logic         cin;
  logic [N-1:0] res;
  logic         cout, vld;

  logic [31:0]  w_op;
  logic [2:0]   w_kind;
  logic [7:0]   w_amt;
  logic         w_cin;
  logic [31:0]  w_res;
  logic         w_cout, w_vld;

  int checks = 0;
  int fails  = 0;

  shift_carry_unit #(.W(N), .AW(8)) dut_i (
    .operand_i(op), .kind_i(kind), .amount_i(amt), .carry_i(cin),
    .result_o(res), .carry_o(cout), .valid_o(vld));

  shift_carry_unit #(.W(32), .AW(8)) dut_wide_i (
    .operand_i(w_op), .kind_i(w_kind), .amount_i(w_amt), .carry_i(w_cin),
    .result_o(w_res), .carry_o(w_cout), .valid_o(w_vld));

  task automatic check(input string req, input logic [31:0] gr, input logic [31:0] er,
                       input logic gc, input logic ec, input logic gv, input logic ev);
    checks++;
    if (gr !== er || gc !== ec || gv !== ev) begin
      fails++;
      $display("FAIL %s: result=%h carry=%b valid=%b expected result=%h carry=%b valid=%b",
               req, gr, gc, gv, er, ec, ev);
    end
  endtask

  task automatic model(input int v, input int k, input int a, input int c,
                       output int er, output int ec, output int ev, output string req);
    int s, r;
    er = v; ec = c; ev = 0;
    if (k > 4) begin req = "R1"; return; end
    if (k == 4) begin
      req = "R6"; er = (c << (N-1)) | (v >> 1); ec = v & 1; ev = 1; return;
    end
    if (a == 0) begin req = "R7"; return; end
    ev = 1;
    case (k)
      0: begin
        req = (a >= N) ? "R8" : "R2";
        er  = (a >= N) ? 0 : ((v << a) % (1 << N));
        ec  = (a > N) ? 0 : ((v >> (N - a)) & 1);
      end
      1: begin
        req = (a >= N) ? "R8" : "R3";
        er  = (a >= N) ? 0 : (v >> a);
        ec  = (a > N) ? 0 : ((v >> (a - 1)) & 1);
      end
      2: begin
        req = "R4";
        s   = (v >= (1 << (N-1))) ? v - (1 << N) : v;
        s   = (a >= N) ? ((s < 0) ? -1 : 0) : (s >>> a);
        er  = s & ((1 << N) - 1);
        ec  = (v >> (((a < N) ? a : N) - 1)) & 1;
      end
      default: begin
        req = "R5";
        r   = a % N;
        er  = ((v >> r) | (v << (N - r))) & ((1 << N) - 1);
        ec  = (er >> (N-1)) & 1;
      end
    endcase
  endtask

  task automatic apply8(input int v, input int k, input int a, input int c);
    int er, ec, ev;
    string req;
    @(posedge clk);
    op = N'(v); kind = 3'(k); amt = 8'(a); cin = 1'(c);
    @(negedge clk);
    model(v, k, a, c, er, ec, ev, req);
    check(req, 32'(res), 32'(er), cout, 1'(ec), vld, 1'(ev));
  endtask

  task automatic apply32(input string req, input logic [31:0] v, input int k, input int a,
                         input logic c, input logic [31:0] er, input logic ec, input logic ev);
    @(posedge clk);
    w_op = v; w_kind = 3'(k); w_amt = 8'(a); w_cin = c;
    @(negedge clk);
    check(req, w_res, er, w_cout, ec, w_vld, ev);
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: result=timeout expected result=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int amts[15] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 15, 16, 100, 255};
    op = '0; kind = '0; amt = '0; cin = 1'b0;
    w_op = '0; w_kind = '0; w_amt = '0; w_cin = 1'b0;

    apply8(8'hA5, 4, 0, 1);   // R6 idle state with zero amount
    for (int k = 0; k < 8; k++)
      for (int ai = 0; ai < 15; ai++)
        for (int c = 0; c < 2; c++)
          for (int v = 0; v < 256; v++)
            apply8(v, k, amts[ai], c);

    apply32("R2", 32'h8000_0001, 0, 1,   1'b0, 32'h0000_0002, 1'b1, 1'b1);
    apply32("R8", 32'h0000_0001, 0, 32,  1'b0, 32'h0,         1'b1, 1'b1);
    apply32("R8", 32'h8000_0000, 1, 33,  1'b1, 32'h0,         1'b0, 1'b1);
    apply32("R3", 32'hF000_0010, 1, 5,   1'b0, 32'h0780_0000, 1'b1, 1'b1);
    apply32("R4", 32'h8000_0000, 2, 200, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b1);
    apply32("R4", 32'h8000_0010, 2, 4,   1'b0, 32'hF800_0001, 1'b0, 1'b1);
    apply32("R5", 32'h0000_0003, 3, 33,  1'b0, 32'h8000_0001, 1'b1, 1'b1);
    apply32("R5", 32'h1234_5678, 3, 64,  1'b1, 32'h1234_5678, 1'b0, 1'b1);
    apply32("R6", 32'h0000_0003, 4, 77,  1'b1, 32'h8000_0001, 1'b1, 1'b1);
    apply32("R7", 32'hDEAD_BEEF, 3, 0,   1'b1, 32'hDEAD_BEEF, 1'b1, 1'b0);
    apply32("R1", 32'hCAFE_0000, 6, 3,   1'b0, 32'hCAFE_0000, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule